// File: doc/BRIEF.md
# Microsecond Free-Running Timer with Periodic Tick Requests

This block keeps a 12-bit count of elapsed microseconds. A prescaler divides the system clock down to one enable pulse per microsecond (divide-by-12 for a 12 MHz clock by default), and each such pulse advances the counter by one. The counter never stops. It wraps from its top value back to zero, so software can measure intervals of up to roughly four milliseconds by subtracting two samples.

Two periodic requests come from fixed bit boundaries of the count. The fast one fires every 128 counts, when the low seven bits return to zero. The slow one fires every 1024 counts, when the low ten bits return to zero, and it serves as the millisecond housekeeping tick of a USB device. Each request gives a one-cycle pulse and also sets a sticky pending flag, which software clears with a strobe.

Software reads the 12-bit value through an 8-bit port in two steps. Reading the low byte also captures the upper bits into a shadow register. A later high-byte read returns that shadow, so the two bytes always belong to the same sample.

Top module: `usec_timer`

## Requirements
- R1: While `rst_n` is low at a clock edge, the count, the shadow register, both request pulses and both pending flags are cleared to zero.
- R2: With `run_en` high, the count rises by exactly one for every `CLK_DIV` clock cycles (default 12). After reset, the first increment lands on the `CLK_DIV`-th enabled edge.
- R3: While `run_en` is low, neither the prescaler nor the count advances. Counting resumes from where it stopped.
- R4: The count wraps from 4095 to 0 and keeps counting.
- R5: `irq_fast` is high for exactly the one cycle in which an increment has just made count bits [6:0] zero, which is once every 128 counts.
- R6: `irq_slow` is high for exactly the one cycle in which an increment has just made count bits [9:0] zero, which is once every 1024 counts.
- R7: A pending flag becomes 1 on the edge that follows a cycle with its request pulse high. It then stays 1 until an edge at which its clear input is high.
- R8: If a request pulse and the clear input of the same flag are both high in one cycle, the flag is 1 after that edge.
- R9: With `rd_hi` low, `rd_data` shows count bits [7:0]. An edge with `rd_lo` high copies count bits [11:8] into the shadow register. With `rd_hi` high, `rd_data` is {4'b0000, shadow}. The shadow changes at no other time.
- R10: Read strobes have no effect on counting. A low-byte read followed by a high-byte read returns the count as it stood in the low-byte read cycle, even when a carry into bit 8 occurs between the two reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| run_en | input | 1 | Enables the prescaler and the count |
| rd_lo | input | 1 | Low-byte read strobe; captures the upper count bits into the shadow |
| rd_hi | input | 1 | Selects the shadowed upper bits onto `rd_data` |
| rd_data | output | 8 | Read data byte |
| irq_fast | output | 1 | One-cycle pulse every 128 counts |
| irq_slow | output | 1 | One-cycle pulse every 1024 counts |
| clr_fast | input | 1 | Clears the fast pending flag |
| clr_slow | input | 1 | Clears the slow pending flag |
| pend_fast | output | 1 | Sticky pending flag for the fast request |
| pend_slow | output | 1 | Sticky pending flag for the slow request |

## Verification
The embedded properties check the following on every cycle:
- the count moves by one or holds, depending on the prescaler tick;
- the prescaler freezes while disabled;
- each request pulse coincides with a zero in its bit field;
- a pending flag obeys its set-wins-over-clear rule;
- the shadow changes only on a low-byte read.

The request spacing of 128 and 1024 counts, the exact edge on which the first increment lands after reset, and a full wrap past 4095 can only be shown by the bench's long runs against its own timing model. The same holds for coherent two-byte reads taken just before a carry into bit 8 and for a clear that collides with a request.

// File: rtl/usec_tmr_pkg.sv
// Package: shared defaults and tap indices for the microsecond timer.
// Assumes the count is wider than one read byte.
package usec_tmr_pkg;
    localparam int unsigned CNT_W_DEF  = 12;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned N_TAPS     = 2;
    localparam int unsigned TAP_FAST   = 0;
    localparam int unsigned TAP_SLOW   = 1;
endpackage

// File: rtl/usec_prescale.sv
// Prescaler: divides the system clock into a one-cycle tick every DIV
// enabled cycles. Assumes DIV >= 2. Holds its state while en is low.
module usec_prescale #(
    parameter int unsigned DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int unsigned DW = $clog2(DIV);
    localparam logic [DW-1:0] LAST = DW'(DIV - 1);

    logic [DW-1:0] div_q;

    // Tick on the last phase of the division cycle, only when enabled.
    assign tick = en && (div_q == LAST);

    // Phase counter: advance when enabled, return to zero after the last phase.
    always_ff @(posedge clk) begin
        if (!rst_n)        div_q <= '0;
        else if (tick)     div_q <= '0;
        else if (en)       div_q <= div_q + 1'b1;
    end

    AST_PRESCALE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(div_q)) else $error("prescaler moved while disabled"); // R3
endmodule

// File: rtl/usec_count.sv
// Free-running counter with fixed-boundary tap pulses. A tap pulses for one
// cycle right after an increment clears its low TAP bits. Assumes the tap
// widths are below the counter width.
module usec_count #(
    parameter int unsigned CNT_W     = 12,
    parameter int unsigned FAST_BITS = 7,
    parameter int unsigned SLOW_BITS = 10
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                tick,
    output logic [CNT_W-1:0]                    cnt,
    output logic [usec_tmr_pkg::N_TAPS-1:0]     tap_pulse
);
    // Count register: one step per tick, natural wrap at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt <= '0;
        else if (tick) cnt <= cnt + 1'b1;
    end

    for (genvar t = 0; t < int'(usec_tmr_pkg::N_TAPS); t++) begin : g_tap
        localparam int unsigned TB = (t == int'(usec_tmr_pkg::TAP_FAST)) ? FAST_BITS : SLOW_BITS;
        // Tap pulse: registered with the increment that rolls the field over.
        always_ff @(posedge clk) begin
            if (!rst_n) tap_pulse[t] <= 1'b0;
            else        tap_pulse[t] <= tick && (&cnt[TB-1:0]);
        end
        AST_TAP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
            tap_pulse[t] |-> (cnt[TB-1:0] == '0)) else $error("tap pulse off boundary"); // R5 R6
    end

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt == $past(cnt) + CNT_W'(1))) else $error("count step wrong"); // R2 R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt)) else $error("count moved without tick"); // R3
    AST_SLOW_IMPLIES_FAST: assert property (@(posedge clk) disable iff (!rst_n)
        tap_pulse[usec_tmr_pkg::TAP_SLOW] |-> tap_pulse[usec_tmr_pkg::TAP_FAST])
        else $error("slow tap without fast tap"); // R6
endmodule

// File: rtl/usec_pend.sv
// Sticky pending flag: set by a request pulse, cleared by a strobe.
// A set in the same cycle as a clear wins.
module usec_pend (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);
    // Flag register: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag) else $error("pending not set"); // R8
    AST_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !set) |=> !flag) else $error("pending not cleared"); // R7
    AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag) else $error("pending dropped"); // R7
endmodule

// File: rtl/usec_rdport.sv
// Byte read port: shows the low byte live. A low-byte read captures the
// upper count bits into a shadow, which a high-byte read returns.
// Assumes CNT_W is greater than BYTE_W and at most twice it.
module usec_rdport #(
    parameter int unsigned CNT_W  = 12,
    parameter int unsigned BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              rd_lo,
    input  logic              rd_hi,
    output logic [BYTE_W-1:0] rd_data
);
    localparam int unsigned HI_W  = CNT_W - BYTE_W;
    localparam int unsigned PAD_W = BYTE_W - HI_W;

    logic [HI_W-1:0] shadow;

    // Shadow register: capture upper bits on a low-byte read.
    always_ff @(posedge clk) begin
        if (!rst_n)     shadow <= '0;
        else if (rd_lo) shadow <= cnt[CNT_W-1:BYTE_W];
    end

    // Output mux: shadowed upper bits or live low byte.
    always_comb begin
        if (rd_hi) rd_data = {{PAD_W{1'b0}}, shadow};
        else       rd_data = cnt[BYTE_W-1:0];
    end

    AST_SHADOW_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo |=> (shadow == $past(cnt[CNT_W-1:BYTE_W]))) else $error("shadow capture"); // R9
    AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_lo |=> $stable(shadow)) else $error("shadow changed"); // R9
endmodule

// File: rtl/usec_timer.sv
// Top: microsecond free-running timer with two periodic requests, sticky
// pending flags and a coherent two-step byte read of the count.
// Assumes a system clock of CLK_DIV MHz so that one count is one microsecond.
module usec_timer #(
    parameter int unsigned CLK_DIV   = 12,
    parameter int unsigned CNT_W     = usec_tmr_pkg::CNT_W_DEF,
    parameter int unsigned FAST_BITS = 7,
    parameter int unsigned SLOW_BITS = 10
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              run_en,
    input  logic                              rd_lo,
    input  logic                              rd_hi,
    output logic [usec_tmr_pkg::BYTE_W-1:0]   rd_data,
    output logic                              irq_fast,
    output logic                              irq_slow,
    input  logic                              clr_fast,
    input  logic                              clr_slow,
    output logic                              pend_fast,
    output logic                              pend_slow
);
    localparam int unsigned NT = usec_tmr_pkg::N_TAPS;

    logic             us_tick;
    logic [CNT_W-1:0] cnt;
    logic [NT-1:0]    req;
    logic [NT-1:0]    clr;
    logic [NT-1:0]    pend;

    usec_prescale #(.DIV(CLK_DIV)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(run_en), .tick(us_tick)
    );

    usec_count #(.CNT_W(CNT_W), .FAST_BITS(FAST_BITS), .SLOW_BITS(SLOW_BITS)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(us_tick), .cnt(cnt), .tap_pulse(req)
    );

    assign clr[usec_tmr_pkg::TAP_FAST] = clr_fast;
    assign clr[usec_tmr_pkg::TAP_SLOW] = clr_slow;

    for (genvar t = 0; t < int'(NT); t++) begin : g_pend
        usec_pend u_pend (
            .clk(clk), .rst_n(rst_n), .set(req[t]), .clr(clr[t]), .flag(pend[t])
        );
    end

    usec_rdport #(.CNT_W(CNT_W), .BYTE_W(usec_tmr_pkg::BYTE_W)) u_rd (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .rd_lo(rd_lo), .rd_hi(rd_hi), .rd_data(rd_data)
    );

    assign irq_fast  = req[usec_tmr_pkg::TAP_FAST];
    assign irq_slow  = req[usec_tmr_pkg::TAP_SLOW];
    assign pend_fast = pend[usec_tmr_pkg::TAP_FAST];
    assign pend_slow = pend[usec_tmr_pkg::TAP_SLOW];

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!irq_fast && !irq_slow && !pend_fast && !pend_slow))
        else $error("outputs not cleared by reset"); // R1
endmodule

// File: tb/usec_timer_test.sv
// Scoreboard bench: a timing model predicts the count, the pulses and the
// flags; a read task pushes expected and observed values into queues and
// a monitor pops and compares them.
module usec_timer_test;
    localparam int DIV = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic       rd_lo = 1'b0, rd_hi = 1'b0;
    logic       clr_fast = 1'b0, clr_slow = 1'b0;
    logic [7:0] rd_data;
    logic       irq_fast, irq_slow, pend_fast, pend_slow;

    int checks = 0, errors = 0;
    bit mon_on = 0;
    bit done = 0;

    logic [11:0] exp_q[$];
    logic [11:0] act_q[$];

    // Reference model state.
    int          k = 0;
    logic [11:0] m_cnt = 0;
    logic        m_if = 0, m_is = 0, m_pf = 0, m_ps = 0;

    usec_timer uut (
        .clk(clk), .rst_n(rst_n), .run_en(run_en), .rd_lo(rd_lo), .rd_hi(rd_hi),
        .rd_data(rd_data), .irq_fast(irq_fast), .irq_slow(irq_slow),
        .clr_fast(clr_fast), .clr_slow(clr_slow),
        .pend_fast(pend_fast), .pend_slow(pend_slow)
    );

    always #10 clk = ~clk;

    // Model update at each edge; inputs change only at falling edges.
    always @(posedge clk) begin
        logic [11:0] nc;
        if (!rst_n) begin
            k = 0; m_cnt = 0; m_if = 0; m_is = 0; m_pf = 0; m_ps = 0;
        end else begin
            m_pf = m_if | (m_pf & ~clr_fast);
            m_ps = m_is | (m_ps & ~clr_slow);
            if (run_en) k = k + 1;
            nc = 12'((k / DIV) % 4096);
            m_if = (nc != m_cnt) && (nc[6:0] == 0);
            m_is = (nc != m_cnt) && (nc[9:0] == 0);
            m_cnt = nc;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Per-cycle monitor for pulses and flags, plus the read scoreboard.
    always @(negedge clk) begin
        #2;
        if (mon_on) begin
            chk("R5 irq_fast", irq_fast, m_if);
            chk("R6 irq_slow", irq_slow, m_is);
            chk("R7 pend_fast", pend_fast, m_pf);
            chk("R7 pend_slow", pend_slow, m_ps);
        end
        while (exp_q.size() > 0 && act_q.size() > 0) begin
            logic [11:0] e, a;
            e = exp_q.pop_front();
            a = act_q.pop_front();
            chk("R2 R4 R9 R10 read", a, e);
        end
    end

    // Driver: two-step read; pushes the model value and the observed value.
    task automatic read_timer();
        logic [7:0] lo, hi;
        @(negedge clk);
        rd_lo = 1'b1;
        #1 lo = rd_data;
        exp_q.push_back(m_cnt);
        @(negedge clk);
        rd_lo = 1'b0; rd_hi = 1'b1;
        #1 hi = rd_data;
        chk("R9 high nibble pad", hi[7:4], 4'h0);
        act_q.push_back({hi[3:0], lo});
        @(negedge clk);
        rd_hi = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        logic [11:0] frozen;
        idle(3);
        // R1: state after reset
        rd_hi = 1'b1; #1;
        chk("R1 shadow", rd_data, 8'h00);
        rd_hi = 1'b0; #1;
        chk("R1 count", rd_data, 8'h00);
        chk("R1 pulses", {irq_fast, irq_slow}, 2'b00);
        chk("R1 flags", {pend_fast, pend_slow}, 2'b00);
        mon_on = 1;
        @(negedge clk);
        rst_n = 1'b1; run_en = 1'b1;

        // R2: first increment on the DIV-th enabled edge
        idle(DIV - 1); #1;
        chk("R2 before first step", rd_data, 8'h00);
        idle(1); #1;
        chk("R2 first step", rd_data, 8'h01);

        read_timer();
        idle(100);
        read_timer();

        // R3: freeze while disabled
        run_en = 1'b0;
        idle(1); #1 frozen[7:0] = rd_data;
        idle(60); #1;
        chk("R3 frozen count", rd_data, frozen[7:0]);
        read_timer();
        run_en = 1'b1;

        // R10: low read just before a carry into bit 8
        while (!(m_cnt[7:0] == 8'hFF && (k % DIV) == DIV - 1)) @(negedge clk);
        rd_lo = 1'b1;
        #1 frozen[7:0] = rd_data;
        exp_q.push_back(m_cnt);
        @(negedge clk);
        rd_lo = 1'b0; rd_hi = 1'b1;
        #1 act_q.push_back({rd_data[3:0], frozen[7:0]});
        @(negedge clk);
        rd_hi = 1'b0; #1;
        chk("R10 carry happened", rd_data, 8'h00);

        // R7: clear a pending flag with no collision
        while (!pend_fast) @(negedge clk);
        while (irq_fast) @(negedge clk);
        clr_fast = 1'b1;
        @(negedge clk); clr_fast = 1'b0; #1;
        chk("R7 cleared", pend_fast, 1'b0);

        // R8: clear in the same cycle as the request pulse
        while (!irq_fast) @(negedge clk);
        clr_fast = 1'b1;
        @(negedge clk); clr_fast = 1'b0; #1;
        chk("R8 set wins", pend_fast, 1'b1);

        // R6 and R8 on the slow flag
        while (!irq_slow) @(negedge clk);
        clr_slow = 1'b1;
        @(negedge clk); clr_slow = 1'b0; #1;
        chk("R8 slow set wins", pend_slow, 1'b1);

        // R4: run past a full wrap, reading along the way
        for (int i = 0; i < 12; i++) begin
            idle(4400);
            read_timer();
        end
        chk("R4 wrapped", (k / DIV) > 4096, 1'b1);
        idle(5);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule